// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented logical address into a physical address. A requester presents a segment number, an offset inside that segment and a flag saying whether the access is a write. The segment number selects one entry of a small on-chip table. Each entry holds a base, a limit, a valid bit and a write-permission bit. If the offset falls inside the segment and the access is allowed, the physical address is the base plus the offset, and a downstream memory request is raised. Otherwise the block reports a range fault or a protection fault and suppresses the memory request.

A privileged configuration port loads table entries one at a time. Every segment has its own limit and its own write permission. Two entries may be given the same base, so that one physical region can be reached through two segments, for example as writable data through one and as read-only text through the other. The translation result is registered and appears exactly one clock after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid, `rsp_valid` and `mem_req` are 0, and any access made before the first table write returns error code 1.
- R2: Every cycle with `req_valid` high produces exactly one result with `rsp_valid` high on the following cycle; no result appears without a request, and back-to-back requests give back-to-back results in order.
- R3: When the entry is valid, the offset is strictly less than the limit and the access is permitted, `rsp_err` is 0 and `rsp_paddr` is base plus offset, computed one bit wider than the base so a carry out of the base width is kept.
- R4: An offset equal to or greater than the entry's limit returns error code 1 (range).
- R5: An access to an entry whose valid bit is 0 returns error code 1 (range), for reads and writes alike.
- R6: A write to an entry whose write-permission bit is 0 returns error code 2 (protection); a read of the same entry inside its limit succeeds.
- R7: When an access is both out of range and a forbidden write, the range error (code 1) is reported.
- R8: On any error `rsp_paddr` is 0 and `mem_req` is 0; on success `mem_req` is 1 and `mem_we` equals the request's write flag.
- R9: Two entries loaded with the same base translate the same offset to the same physical address, each under its own limit and permission.
- R10: A table write takes effect on the cycle after it is presented; a request in the same cycle as a write to its entry uses the entry's previous contents.
- R11: Error codes are 0 for success, 1 for range, 2 for protection, and code 3 never occurs; an entry with limit 0 rejects every offset with code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one table entry this cycle |
| cfg_idx | input | 3 | Index of the entry to load |
| cfg_base | input | 16 | Base to store |
| cfg_limit | input | 16 | Limit (segment length) to store |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_wr_ok | input | 1 | Write-permission bit to store |
| req_valid | input | 1 | Translation request present |
| req_seg | input | 3 | Segment number of the request |
| req_off | input | 16 | Offset inside the segment |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Result present, one cycle after the request |
| rsp_err | output | 2 | 0 success, 1 range, 2 protection |
| rsp_paddr | output | 17 | Physical address, 0 on error |
| mem_req | output | 1 | Downstream memory access issued |
| mem_we | output | 1 | Downstream access is a write |

## Verification
Accesses are made at offset zero, at limit minus one and at exactly the limit, so an off-by-one in the strict comparison shows up as a wrong code at one end. Reads and writes go to read-only and writable segments, and an out-of-range write to a read-only segment separates the two fault kinds and their order. Two aliased entries with different permissions, a base near the top of its range whose sum carries, an invalid entry and a zero-limit entry each separate one field's effect from the others. A request that meets a write to its own entry in the same cycle, followed by an immediate repeat, tells whether the table update lands one cycle late as required, and a run of back-to-back requests with idle gaps checks the one-cycle result timing.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int unsigned SEG_COUNT = 8;
    localparam int unsigned ADDR_W    = 16;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_RANGE = 2'd1,
        ERR_PROT  = 2'd2
    } xl_err_e;

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int unsigned N_SEG = SEG_COUNT,
    parameter int unsigned W     = ADDR_W,
    parameter int unsigned IDX_W = (N_SEG > 1) ? $clog2(N_SEG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_base,
    input  logic [W-1:0]     wr_limit,
    input  logic             wr_valid,
    input  logic             wr_perm,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_base,
    output logic [W-1:0]     rd_limit,
    output logic             rd_valid,
    output logic             rd_perm
);

    typedef struct packed {
        logic [W-1:0] base;
        logic [W-1:0] limit;
        logic         valid;
        logic         perm;
    } ent_t;

    ent_t tbl_d [N_SEG];
    ent_t tbl_q [N_SEG];

    // Next-state: one entry replaced per write, the others held.
    always_comb begin
        for (int i = 0; i < N_SEG; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tbl_d[i].base  = wr_base;
                tbl_d[i].limit = wr_limit;
                tbl_d[i].valid = wr_valid;
                tbl_d[i].perm  = wr_perm;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SEG; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_SEG; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    // Read port sees the registered contents only (old value during a write).
    always_comb begin
        rd_base  = tbl_q[rd_idx].base;
        rd_limit = tbl_q[rd_idx].limit;
        rd_valid = tbl_q[rd_idx].valid;
        rd_perm  = tbl_q[rd_idx].perm;
    end

    AST_TBL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)].base  == $past(wr_base)) &&
                  (tbl_q[$past(wr_idx)].limit == $past(wr_limit)) &&
                  (tbl_q[$past(wr_idx)].valid == $past(wr_valid))); // R10

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int unsigned W  = ADDR_W,
    parameter int unsigned PW = W + 1
) (
    input  logic          ent_valid,
    input  logic          ent_perm,
    input  logic [W-1:0]  ent_base,
    input  logic [W-1:0]  ent_limit,
    input  logic [W-1:0]  off,
    input  logic          is_write,
    output xl_err_e       err,
    output logic [PW-1:0] paddr
);

    logic in_range;
    logic prot_fail;

    always_comb begin
        // Strict comparison: an offset equal to the limit is outside.
        in_range  = ent_valid && (off < ent_limit);
        prot_fail = is_write && !ent_perm;
        if (!in_range) begin
            err   = ERR_RANGE;       // range checked first
            paddr = '0;
        end else if (prot_fail) begin
            err   = ERR_PROT;
            paddr = '0;
        end else begin
            err   = ERR_NONE;
            paddr = PW'(ent_base) + PW'(off);
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int unsigned N_SEG = SEG_COUNT,
    parameter int unsigned W     = ADDR_W,
    parameter int unsigned IDX_W = (N_SEG > 1) ? $clog2(N_SEG) : 1,
    parameter int unsigned PW    = W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [W-1:0]     cfg_base,
    input  logic [W-1:0]     cfg_limit,
    input  logic             cfg_valid,
    input  logic             cfg_wr_ok,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_seg,
    input  logic [W-1:0]     req_off,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [1:0]       rsp_err,
    output logic [PW-1:0]    rsp_paddr,
    output logic             mem_req,
    output logic             mem_we
);

    typedef struct packed {
        logic          valid;
        xl_err_e       err;
        logic [PW-1:0] paddr;
        logic          mreq;
        logic          mwe;
    } rsp_t;

    logic [W-1:0]  ent_base;
    logic [W-1:0]  ent_limit;
    logic          ent_valid;
    logic          ent_perm;
    xl_err_e       chk_err;
    logic [PW-1:0] chk_paddr;

    rsp_t rsp_d;
    rsp_t rsp_q;

    seg_table #(
        .N_SEG (N_SEG),
        .W     (W),
        .IDX_W (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_base  (cfg_base),
        .wr_limit (cfg_limit),
        .wr_valid (cfg_valid),
        .wr_perm  (cfg_wr_ok),
        .rd_idx   (req_seg),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_valid (ent_valid),
        .rd_perm  (ent_perm)
    );

    seg_check #(
        .W  (W),
        .PW (PW)
    ) u_check (
        .ent_valid (ent_valid),
        .ent_perm  (ent_perm),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .off       (req_off),
        .is_write  (req_write),
        .err       (chk_err),
        .paddr     (chk_paddr)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = ERR_NONE;
        if (req_valid) begin
            rsp_d.err = chk_err;
            if (chk_err == ERR_NONE) begin
                rsp_d.paddr = chk_paddr;
                rsp_d.mreq  = 1'b1;
                rsp_d.mwe   = req_write;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_paddr = rsp_q.paddr;
    assign mem_req   = rsp_q.mreq;
    assign mem_we    = rsp_q.mwe;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err != 2'd0) |-> (rsp_paddr == '0) && !mem_req); // R8
    AST_MREQ_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> rsp_valid && (rsp_err == 2'd0)); // R8
    AST_MWE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req && $past(req_write)); // R8
    AST_PROT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err == 2'd2) |-> $past(req_write)); // R6
    AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err != 2'd3); // R11

endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_limit = '0;
    logic        cfg_valid = 1'b0;
    logic        cfg_wr_ok = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_err;
    logic [16:0] rsp_paddr;
    logic        mem_req;
    logic        mem_we;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_valid(cfg_valid), .cfg_wr_ok(cfg_wr_ok),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_we(mem_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        logic [1:0]  err;
        logic [16:0] pa;
        logic        mr;
        logic        mw;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    // Bench model of the table
    logic [15:0] m_base [NS];
    logic [15:0] m_lim  [NS];
    logic        m_val  [NS];
    logic        m_wok  [NS];

    // Pending model update, applied at the clock edge
    bit          pend = 1'b0;
    int          p_idx;
    logic [15:0] p_base, p_lim;
    logic        p_val, p_wok;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input string act, input string expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %s expected %s", what, act, expv);
        end
    endtask

    task automatic put_cfg(input int idx, input logic [15:0] b, input logic [15:0] l,
                           input logic v, input logic w);
        cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_base = b; cfg_limit = l;
        cfg_valid = v; cfg_wr_ok = w;
        pend = 1'b1; p_idx = idx; p_base = b; p_lim = l; p_val = v; p_wok = w;
    endtask

    task automatic put_req(input int seg, input logic [15:0] off, input logic wr, input string tag);
        exp_t e;
        e.cyc = cyc + 1;
        e.tag = tag;
        if (!m_val[seg] || off >= m_lim[seg]) begin
            e.err = 2'd1; e.pa = '0; e.mr = 1'b0; e.mw = 1'b0;
        end else if (wr && !m_wok[seg]) begin
            e.err = 2'd2; e.pa = '0; e.mr = 1'b0; e.mw = 1'b0;
        end else begin
            e.err = 2'd0; e.pa = {1'b0, m_base[seg]} + {1'b0, off};
            e.mr = 1'b1; e.mw = wr;
        end
        exp_q.push_back(e);
        req_valid = 1'b1; req_seg = seg[2:0]; req_off = off; req_write = wr;
    endtask

    task automatic tick();
        @(posedge clk);
        if (pend) begin
            m_base[p_idx] = p_base; m_lim[p_idx] = p_lim;
            m_val[p_idx] = p_val; m_wok[p_idx] = p_wok;
            pend = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
    endtask

    // Monitor: compares each result against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", "rsp_valid=1", "no result");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.cyc == cyc, {e.tag, " R2 timing"},
                      $sformatf("cycle %0d", cyc), $sformatf("cycle %0d", e.cyc));
                check(rsp_err == e.err && rsp_paddr == e.pa && mem_req == e.mr && mem_we == e.mw,
                      e.tag,
                      $sformatf("err=%0d pa=%h mreq=%b mwe=%b", rsp_err, rsp_paddr, mem_req, mem_we),
                      $sformatf("err=%0d pa=%h mreq=%b mwe=%b", e.err, e.pa, e.mr, e.mw));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < NS; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_val[i] = 1'b0; m_wok[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0 && mem_req == 1'b0, "R1 reset outputs",
              $sformatf("rsp_valid=%b mem_req=%b", rsp_valid, mem_req), "0 0");

        put_req(0, 16'h0000, 1'b0, "R1 R5 access before any load"); tick();
        put_req(7, 16'h0010, 1'b1, "R1 R5 write before any load");  tick();

        put_cfg(0, 16'h1000, 16'h0100, 1'b1, 1'b0); tick();
        put_cfg(1, 16'h8000, 16'h2000, 1'b1, 1'b1); tick();
        put_cfg(2, 16'h1000, 16'h0100, 1'b1, 1'b1); tick();
        put_cfg(3, 16'h4000, 16'h0100, 1'b0, 1'b1); tick();
        put_cfg(4, 16'hFFF0, 16'hFFFF, 1'b1, 1'b1); tick();
        put_cfg(5, 16'h2000, 16'h0000, 1'b1, 1'b1); tick();

        put_req(0, 16'h0000, 1'b0, "R3 offset zero");              tick();
        put_req(0, 16'h00FF, 1'b0, "R3 limit minus one");          tick();
        put_req(0, 16'h0100, 1'b0, "R4 offset equals limit");      tick();
        put_req(0, 16'hFFFF, 1'b0, "R4 offset far beyond limit");  tick();
        put_req(0, 16'h0004, 1'b1, "R6 write to read-only");       tick();
        put_req(0, 16'h0004, 1'b0, "R6 read of read-only");        tick();
        put_req(0, 16'h0100, 1'b1, "R7 range beats protection");   tick();
        put_req(2, 16'h0004, 1'b0, "R9 alias read same address");  tick();
        put_req(2, 16'h0004, 1'b1, "R9 alias write allowed");      tick();
        put_req(3, 16'h0008, 1'b0, "R5 invalid entry read");       tick();
        put_req(3, 16'h0008, 1'b1, "R5 invalid entry write");      tick();
        put_req(1, 16'h1FFF, 1'b1, "R8 write success sets mem_we"); tick();
        put_req(4, 16'h0020, 1'b1, "R3 carry past base width");    tick();
        put_req(5, 16'h0000, 1'b0, "R11 zero limit rejects");      tick();

        // R10: write and request to the same entry in one cycle
        put_cfg(3, 16'h4000, 16'h0100, 1'b1, 1'b1);
        put_req(3, 16'h0008, 1'b0, "R10 same-cycle sees old entry"); tick();
        put_req(3, 16'h0008, 1'b0, "R10 next cycle sees new entry"); tick();

        // R2: back-to-back stream, then idle
        for (int k = 0; k < 6; k++) begin
            put_req(k % 3, 16'(k * 16'h40), k[0], "R2 back-to-back");
            tick();
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered",
              $sformatf("%0d pending", exp_q.size()), "0 pending");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule